// File: doc/BRIEF.md
# Bitfield Extract, Insert and Byte-Swap Unit

This unit takes one operation at a time, chosen by a 3-bit opcode. It can pull a contiguous bitfield out of a source word. It can deposit the low bits of a source into a chosen window of an old destination word. It can exchange the two bytes inside every 16-bit halfword. In the doubleword case it can also reverse the order of the four halfwords. Each operation has a 32-bit form and a 64-bit form. The 32-bit forms use only the low half of the operands, and their result is sign-extended from bit 31 to the full register width.

The caller presents the operands and pulses `inValid` for one cycle. On the next rising edge the unit registers the result and raises `resValid` for exactly one cycle. Between strobes the result register holds its value. The unit does not check position/size pairs: any pair whose field runs past the top of the word gives an unspecified result.

Top module: `bfu_top`

## Requirements
- R1: After reset, `resValid` is 0 and `result` is 0.
- R2: `resValid` is 1 in the cycle after each cycle in which `inValid` is 1, and 0 otherwise. `result` changes only on the edge that follows an `inValid` cycle.
- R3: Opcode 100 (wide extract) returns `(srcOp >> pos)` masked to its low `size` bits, with zeros above them.
- R4: A size equal to the full width (64 wide, 32 narrow) gives an all-ones mask. A wide extract with pos 0 and size 64 returns `srcOp` unchanged.
- R5: Opcode 101 (wide insert) builds the mask `(2^size-1) << pos`. It returns `oldDst` outside the mask and `srcOp << pos` inside it.
- R6: Opcodes 000 (narrow extract) and 001 (narrow insert) apply R3 and R5 to bits [31:0] of the operands, using `pos[4:0]`. The 32-bit result is sign-extended from bit 31.
- R7: Opcode 010 (narrow byte swap) exchanges the bytes in each halfword of bits [31:0]. The result is sign-extended from bit 31.
- R8: Opcode 110 (wide byte swap) exchanges the two bytes in every halfword of the 64-bit source.
- R9: Opcode 111 (halfword reverse) first swaps the halfwords within each 32-bit word and then swaps the two words. As a result, halfword k of the output equals halfword 3-k of the source.
- R10: Opcode 011 is reserved and yields an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | One-cycle strobe that starts an operation |
| opcode | input | 3 | Operation select; bit 2 set selects the 64-bit form |
| srcOp | input | DW | Source operand |
| oldDst | input | DW | Old destination value, used by insert |
| pos | input | $clog2(DW) | Bit position of the field |
| size | input | $clog2(DW)+1 | Field width in bits |
| result | output | DW | Registered result |
| resValid | output | 1 | Result-valid flag, high for one cycle |

## Verification
The assertions check the strobe-to-valid timing and the hold of the result between strobes on every cycle. They also check that every narrow result is sign-extended from bit 31 and that the reserved opcode gives zero. The arithmetic content of each operation cannot be seen by these properties. That content is covered only by the bench's sweeps: every legal position/size pair of the narrow extract and insert, position sweeps of the wide forms, the full-width mask corners, and byte- and halfword-swap patterns. The bench computes every expected value bit by bit.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

  localparam logic [2:0] OP_EXT_N = 3'b000;
  localparam logic [2:0] OP_INS_N = 3'b001;
  localparam logic [2:0] OP_SBH_N = 3'b010;
  localparam logic [2:0] OP_RSVD  = 3'b011;
  localparam logic [2:0] OP_EXT_W = 3'b100;
  localparam logic [2:0] OP_INS_W = 3'b101;
  localparam logic [2:0] OP_SBH_W = 3'b110;
  localparam logic [2:0] OP_SHD_W = 3'b111;

  typedef enum logic [2:0] {
    K_EXT  = 3'd0,
    K_INS  = 3'd1,
    K_SBH  = 3'd2,
    K_SHD  = 3'd3,
    K_ZERO = 3'd4
  } op_kind_e;

  typedef struct packed {
    logic     load;
    logic     wide;
    op_kind_e kind;
  } bfu_ctrl_t;

endpackage

// File: rtl/bfu_ctrl.sv
module bfu_ctrl
  import bfu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [2:0] opcode,
  output bfu_ctrl_t  ctrl,
  output logic       resValid
);

  op_kind_e kindDec;

  always_comb begin
    unique case (opcode)
      OP_EXT_N, OP_EXT_W: kindDec = K_EXT;
      OP_INS_N, OP_INS_W: kindDec = K_INS;
      OP_SBH_N, OP_SBH_W: kindDec = K_SBH;
      OP_SHD_W:           kindDec = K_SHD;
      OP_RSVD:            kindDec = K_ZERO;
      default:            kindDec = K_ZERO;
    endcase
  end

  always_comb begin
    ctrl.load = inValid;
    ctrl.wide = opcode[2];
    ctrl.kind = kindDec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= inValid;
  end

endmodule

// File: rtl/bfu_datapath.sv
module bfu_datapath
  import bfu_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  bfu_ctrl_t              ctrl,
  input  logic [DW-1:0]          srcOp,
  input  logic [DW-1:0]          oldDst,
  input  logic [$clog2(DW)-1:0]  pos,
  input  logic [$clog2(DW):0]    size,
  output logic [DW-1:0]          result
);

  localparam int HW     = DW / 2;
  localparam int POSW   = $clog2(DW);
  localparam int NHALF  = DW / 16;

  // Wide masks: computed one bit wider so that size == DW yields all ones.
  logic [DW:0]    oneW, spanW;
  logic [DW-1:0]  maskW, insMaskW, extW, insW;
  // Narrow masks on the low half.
  logic [HW:0]    oneN, spanN;
  logic [HW-1:0]  maskN, insMaskN, extN, insN, srcN, dstN;
  logic [POSW-2:0] posN;
  logic [DW-1:0]  sbhW, shdW, nextRes;

  always_comb begin
    oneW     = {{DW{1'b0}}, 1'b1};
    spanW    = (oneW << size) - 1'b1;
    maskW    = spanW[DW-1:0];
    extW     = (srcOp >> pos) & maskW;
    insMaskW = maskW << pos;
    insW     = (oldDst & ~insMaskW) | ((srcOp << pos) & insMaskW);

    srcN     = srcOp[HW-1:0];
    dstN     = oldDst[HW-1:0];
    posN     = pos[POSW-2:0];
    oneN     = {{HW{1'b0}}, 1'b1};
    spanN    = (oneN << size) - 1'b1;
    maskN    = spanN[HW-1:0];
    extN     = (srcN >> posN) & maskN;
    insMaskN = maskN << posN;
    insN     = (dstN & ~insMaskN) | ((srcN << posN) & insMaskN);
  end

  for (genvar h = 0; h < NHALF; h++) begin : g_swap
    assign sbhW[16*h +: 8]     = srcOp[16*h + 8 +: 8];
    assign sbhW[16*h + 8 +: 8] = srcOp[16*h +: 8];
    assign shdW[16*h +: 16]    = srcOp[DW - 16*(h+1) +: 16];
  end

  function automatic logic [DW-1:0] sext(input logic [HW-1:0] v);
    return {{HW{v[HW-1]}}, v};
  endfunction

  always_comb begin
    unique case (ctrl.kind)
      K_EXT:   nextRes = ctrl.wide ? extW : sext(extN);
      K_INS:   nextRes = ctrl.wide ? insW : sext(insN);
      K_SBH:   nextRes = ctrl.wide ? sbhW : sext(sbhW[HW-1:0]);
      K_SHD:   nextRes = shdW;
      default: nextRes = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          result <= '0;
    else if (ctrl.load) result <= nextRes;
  end

endmodule

// File: rtl/bfu_top.sv
module bfu_top
  import bfu_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [2:0]            opcode,
  input  logic [DW-1:0]         srcOp,
  input  logic [DW-1:0]         oldDst,
  input  logic [$clog2(DW)-1:0] pos,
  input  logic [$clog2(DW):0]   size,
  output logic [DW-1:0]         result,
  output logic                  resValid
);

  bfu_ctrl_t ctrl;

  bfu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opcode   (opcode),
    .ctrl     (ctrl),
    .resValid (resValid)
  );

  bfu_datapath #(.DW(DW)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .srcOp  (srcOp),
    .oldDst (oldDst),
    .pos    (pos),
    .size   (size),
    .result (result)
  );

endmodule

// File: rtl/bfu_checker.sv
module bfu_checker #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic [2:0]    opcode,
  input logic [DW-1:0] result,
  input logic          resValid
);
  localparam int HW = DW / 2;

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> resValid);

  p_valid_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !resValid);

  p_result_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result));

  // R6 / R7: every narrow form leaves the upper half a copy of bit HW-1.
  p_narrow_sext_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !opcode[2]) |=> (result[DW-1:HW] == {HW{result[HW-1]}}));

  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode == 3'b011) |=> (result == '0));

endmodule

bind bfu_top bfu_checker #(.DW(DW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opcode   (opcode),
  .result   (result),
  .resValid (resValid)
);

// File: tb/tb_bfu_top.sv
`timescale 1ns/1ps
module tb_bfu_top;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [2:0]    opcode = '0;
  logic [DW-1:0] srcOp = '0, oldDst = '0;
  logic [5:0]    pos = '0;
  logic [6:0]    size = '0;
  logic [DW-1:0] result;
  logic          resValid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bfu_top #(.DW(DW)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .srcOp(srcOp), .oldDst(oldDst), .pos(pos), .size(size),
    .result(result), .resValid(resValid)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] fixN(input logic [DW-1:0] v, input bit wide);
    logic [DW-1:0] r = v;
    if (!wide) for (int i = 32; i < DW; i++) r[i] = v[31];
    return r;
  endfunction

  function automatic logic [DW-1:0] refExt(input logic [DW-1:0] s, input int p, input int n, input bit wide);
    logic [DW-1:0] r = '0;
    int w = wide ? 64 : 32;
    for (int i = 0; i < w; i++) if (i < n && p + i < w) r[i] = s[p + i];
    return fixN(r, wide);
  endfunction

  function automatic logic [DW-1:0] refIns(input logic [DW-1:0] s, input logic [DW-1:0] d,
                                           input int p, input int n, input bit wide);
    logic [DW-1:0] r = '0;
    int w = wide ? 64 : 32;
    for (int i = 0; i < w; i++) r[i] = (i >= p && i < p + n) ? s[i - p] : d[i];
    return fixN(r, wide);
  endfunction

  function automatic logic [DW-1:0] refSbh(input logic [DW-1:0] s, input bit wide);
    logic [DW-1:0] r = '0;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = s[8*(b ^ 1) +: 8];
    return fixN(r, wide);
  endfunction

  function automatic logic [DW-1:0] refShd(input logic [DW-1:0] s);
    logic [DW-1:0] r;
    for (int h = 0; h < 4; h++) r[16*h +: 16] = s[16*(3-h) +: 16];
    return r;
  endfunction

  task automatic run(input logic [2:0] op, input logic [DW-1:0] s, input logic [DW-1:0] d,
                     input int p, input int n);
    @(negedge clk);
    opcode = op; srcOp = s; oldDst = d; pos = 6'(p); size = 7'(n); inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    srcOp = ~s;
    checks++;
    if (resValid !== 1'b1) begin
      errors++;
      $display("FAIL R2 resValid got=%b exp=1", resValid);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [DW-1:0] pats [4];
    logic [DW-1:0] held;
    pats[0] = 64'h8123_4567_89AB_CDEF;
    pats[1] = 64'h0F1E_2D3C_4B5A_6978;
    pats[2] = 64'hFFFF_0000_AAAA_5555;
    pats[3] = 64'h7654_3210_FEDC_BA98;

    #1;
    check("R1 result", result, '0);
    check("R1 resValid", {63'b0, resValid}, '0);
    repeat (3) @(negedge clk);
    check("R1 result after reset", result, '0);
    rstN = 1'b1;

    // R2: result holds and valid drops when no strobe
    run(3'b100, pats[0], '0, 0, 64);
    held = result;
    @(negedge clk);
    check("R2 valid low", {63'b0, resValid}, '0);
    check("R2 hold", result, held);
    check("R4 full-width wide extract", held, pats[0]);

    // R3: wide extract sweep
    for (int p = 0; p < 64; p++) begin
      run(3'b100, pats[1], '0, p, 64 - p);
      check("R3 ext wide top", result, refExt(pats[1], p, 64 - p, 1));
      run(3'b100, pats[3], '0, p, 1);
      check("R3 ext wide bit", result, refExt(pats[3], p, 1, 1));
    end

    // R5: wide insert sweep
    for (int p = 0; p < 64; p++) begin
      run(3'b101, pats[2], pats[0], p, 64 - p);
      check("R5 ins wide top", result, refIns(pats[2], pats[0], p, 64 - p, 1));
      run(3'b101, pats[3], pats[1], p, (p % 7) + 1 <= 64 - p ? (p % 7) + 1 : 64 - p);
      check("R5 ins wide mid", result,
            refIns(pats[3], pats[1], p, (p % 7) + 1 <= 64 - p ? (p % 7) + 1 : 64 - p, 1));
    end
    run(3'b101, pats[1], pats[2], 0, 64);
    check("R4 full-width wide insert", result, pats[1]);

    // R6: narrow extract and insert, every legal pair
    for (int p = 0; p < 32; p++) begin
      for (int n = 1; n <= 32 - p; n++) begin
        run(3'b000, pats[(p + n) % 4], '0, p, n);
        check("R6 ext narrow", result, refExt(pats[(p + n) % 4], p, n, 0));
        run(3'b001, pats[n % 4], pats[(p + 1) % 4], p, n);
        check("R6 ins narrow", result, refIns(pats[n % 4], pats[(p + 1) % 4], p, n, 0));
      end
    end
    run(3'b000, 64'h1234_5678_8000_0001, '0, 0, 32);
    check("R4 full-width narrow extract", result, 64'hFFFF_FFFF_8000_0001);

    // R7, R8, R9, R10: swaps and reserved
    for (int k = 0; k < 4; k++) begin
      run(3'b010, pats[k], '0, 0, 0);
      check("R7 sbh narrow", result, refSbh(pats[k], 0));
      run(3'b110, pats[k], '0, 0, 0);
      check("R8 sbh wide", result, refSbh(pats[k], 1));
      run(3'b111, pats[k], '0, 0, 0);
      check("R9 shd", result, refShd(pats[k]));
      run(3'b011, pats[k], pats[k], 3, 5);
      check("R10 reserved", result, '0);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule